// File: doc/BRIEF.md
# Cascadable Programmable Up-Counter

A synchronous up-counter stage, four bits wide by default, that a chip can chain into wider counters, timers and frequency dividers. Two elaboration parameters pick the variant. One selects binary counting (wrap after 15) or decade counting (wrap after 9). The other selects a clear that acts at the next rising clock edge or a clear that acts at once, without a clock.

Each stage has a parallel preset that an active-low load strobe captures at a clock edge, and two count enables. The stage advances only when both enables are high. Only the second enable, the "trail" enable, gates the carry output. To cascade stages, wire each stage's carry to both enables of the next stage. The whole chain then steps on one common clock and needs no extra gating.

Top module: `casc_cnt`

## Requirements
- R1: With synchronous clear, a low `clr_ni` sampled at a rising edge makes `count_o` zero after that edge. This holds whatever the load and enable inputs are.
- R2: With asynchronous clear, a low `clr_ni` forces `count_o` to zero at once, with no clock edge, and holds it at zero while the clear stays low.
- R3: With clear inactive and `load_ni` low, `count_o` takes the value of `preset_i` at the next rising edge, whatever the enables are.
- R4: With clear and load inactive and both `cnt_en_p_i` and `cnt_en_t_i` high, `count_o` advances by one at each rising edge.
- R5: With clear and load inactive and either enable low, `count_o` keeps its value across the edge.
- R6: The binary variant steps from 15 to 0. The decade variant steps from 9 to 0.
- R7: `carry_o` is high exactly when `cnt_en_t_i` is high and `count_o` equals the terminal value (15 for binary, 9 for decade). `cnt_en_p_i` has no effect on `carry_o`.
- R8: In the decade variant, a loaded value from 10 to 15 counts up by one per enabled edge (15 steps to 0). `carry_o` stays low for all of these values.
- R9: N stages, each with its carry driving both enables of the next stage, form one synchronous counter of modulus M^N, where M is 16 or 10. The last stage's carry is high at the all-terminal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, rising edge |
| clr_ni | input | 1 | Active-low clear; synchronous or asynchronous per `SYNC_CLEAR` |
| load_ni | input | 1 | Active-low parallel load strobe |
| preset_i | input | WIDTH | Parallel preset value |
| cnt_en_p_i | input | 1 | Count enable that does not gate the carry |
| cnt_en_t_i | input | 1 | Count enable that also gates the carry |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry, gated by `cnt_en_t_i` |

## Verification
The bench loads every preset value into all four variants under every enable pair, then takes one more step. This exposes a wrong wrap point: a decade stage wrapping at 15, or a binary stage wrapping at 9. It also exposes a stage that decodes carry from the wrong enable or leaves carry open to unused codes 10 to 15. The bench drops the clear in the middle of a cycle while load is active. An asynchronous stage that waits for the clock, or a synchronous stage that clears at once, shows the wrong value before the edge. A stage that lets load beat clear shows the preset after the edge. A three-stage decade chain runs past its full modulus of 1000. A carry that looks ahead to the wrong stage makes the combined value drift away from the cycle count.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/casc_cnt_ctrl.sv
module casc_cnt_ctrl
  import casc_cnt_pkg::*;
(
  input  logic    load_ni,
  input  logic    cnt_en_p_i,
  input  logic    cnt_en_t_i,
  output cnt_op_e op_o
);
  // load outranks the enables; clear is handled in the state register
  always_comb begin
    if (!load_ni)                       op_o = OP_LOAD;
    else if (cnt_en_p_i && cnt_en_t_i)  op_o = OP_COUNT;
    else                                op_o = OP_HOLD;
  end
endmodule

// File: rtl/casc_cnt_next.sv
module casc_cnt_next
  import casc_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter bit          DECADE = 1'b0
) (
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] TERM_VAL = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic [WIDTH-1:0] inc;

  // codes above the terminal step by one and wrap through zero
  assign inc = (cur_i == TERM_VAL) ? '0 : cur_i + WIDTH'(1);

  always_comb begin
    unique case (op_i)
      OP_LOAD:  nxt_o = preset_i;
      OP_COUNT: nxt_o = inc;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/casc_cnt_state.sv
module casc_cnt_state #(
  parameter int unsigned WIDTH      = 4,
  parameter bit          SYNC_CLEAR = 1'b1
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] q_o
);
  if (SYNC_CLEAR) begin : g_sync_clr
    always_ff @(posedge clk_i) begin
      if (!clr_ni) q_o <= '0;
      else         q_o <= nxt_i;
    end
  end else begin : g_async_clr
    always_ff @(posedge clk_i or negedge clr_ni) begin
      if (!clr_ni) q_o <= '0;
      else         q_o <= nxt_i;
    end
  end
endmodule

// File: rtl/casc_cnt_carry.sv
module casc_cnt_carry #(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             cnt_en_t_i,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] TERM_VAL = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  assign carry_o = cnt_en_t_i && (q_i == TERM_VAL);
endmodule

// File: rtl/casc_cnt.sv
module casc_cnt
  import casc_cnt_pkg::*;
#(
  parameter int unsigned WIDTH      = 4,
  parameter bit          DECADE     = 1'b0,
  parameter bit          SYNC_CLEAR = 1'b1
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             cnt_en_p_i,
  input  logic             cnt_en_t_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] TERM_VAL = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] q;

  casc_cnt_ctrl u_ctrl (
    .load_ni    (load_ni),
    .cnt_en_p_i (cnt_en_p_i),
    .cnt_en_t_i (cnt_en_t_i),
    .op_o       (op)
  );

  casc_cnt_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .op_i     (op),
    .cur_i    (q),
    .preset_i (preset_i),
    .nxt_o    (nxt)
  );

  casc_cnt_state #(.WIDTH(WIDTH), .SYNC_CLEAR(SYNC_CLEAR)) u_state (
    .clk_i  (clk_i),
    .clr_ni (clr_ni),
    .nxt_i  (nxt),
    .q_o    (q)
  );

  casc_cnt_carry #(.WIDTH(WIDTH), .DECADE(DECADE)) u_carry (
    .q_i        (q),
    .cnt_en_t_i (cnt_en_t_i),
    .carry_o    (carry_o)
  );

  assign count_o = q;

  if (SYNC_CLEAR) begin : g_sync_chk
    // R1
    sync_clear_chk: assert property (@(posedge clk_i)
      !clr_ni |=> count_o == '0);
  end else begin : g_async_chk
    // R2
    async_clear_chk: assert property (@(negedge clk_i)
      !clr_ni |-> count_o == '0);
  end

  // R3
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !load_ni |=> count_o == $past(preset_i));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (load_ni && !(cnt_en_p_i && cnt_en_t_i)) |=> $stable(count_o));

  // R4
  step_chk: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (load_ni && cnt_en_p_i && cnt_en_t_i && count_o != TERM_VAL)
      |=> count_o == $past(count_o) + WIDTH'(1));

  // R6
  carry_wrap_chk: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (load_ni && carry_o && cnt_en_p_i) |=> count_o == '0);

  if (DECADE) begin : g_dec_chk
    // R8
    dec_range_chk: assert property (@(posedge clk_i) disable iff (!clr_ni)
      (load_ni && count_o <= WIDTH'(9)) |=> count_o <= WIDTH'(9));
  end
endmodule

// File: tb/casc_cnt_tb_top.sv
module casc_cnt_tb_top;
  localparam int NST = 3;

  logic       clk = 1'b0;
  logic       clr_n;
  logic       load_n;
  logic [3:0] pre;
  logic       pe;
  logic       te;
  logic       run;
  logic [3:0] q [4];
  logic       c [4];
  logic [3:0] cq [NST];
  logic       cc [NST];
  logic       cen [NST];
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  // v0 binary/sync, v1 binary/async, v2 decade/sync, v3 decade/async
  casc_cnt #(.WIDTH(4), .DECADE(1'b0), .SYNC_CLEAR(1'b1)) dut_i (
    .clk_i(clk), .clr_ni(clr_n), .load_ni(load_n), .preset_i(pre),
    .cnt_en_p_i(pe), .cnt_en_t_i(te), .count_o(q[0]), .carry_o(c[0]));
  casc_cnt #(.WIDTH(4), .DECADE(1'b0), .SYNC_CLEAR(1'b0)) dut_ba_i (
    .clk_i(clk), .clr_ni(clr_n), .load_ni(load_n), .preset_i(pre),
    .cnt_en_p_i(pe), .cnt_en_t_i(te), .count_o(q[1]), .carry_o(c[1]));
  casc_cnt #(.WIDTH(4), .DECADE(1'b1), .SYNC_CLEAR(1'b1)) dut_ds_i (
    .clk_i(clk), .clr_ni(clr_n), .load_ni(load_n), .preset_i(pre),
    .cnt_en_p_i(pe), .cnt_en_t_i(te), .count_o(q[2]), .carry_o(c[2]));
  casc_cnt #(.WIDTH(4), .DECADE(1'b1), .SYNC_CLEAR(1'b0)) dut_da_i (
    .clk_i(clk), .clr_ni(clr_n), .load_ni(load_n), .preset_i(pre),
    .cnt_en_p_i(pe), .cnt_en_t_i(te), .count_o(q[3]), .carry_o(c[3]));

  for (genvar g = 0; g < NST; g++) begin : g_chain
    if (g == 0) begin : g_head
      assign cen[g] = run;
    end else begin : g_tail
      assign cen[g] = cc[g-1];
    end
    casc_cnt #(.WIDTH(4), .DECADE(1'b1), .SYNC_CLEAR(1'b1)) u_stage (
      .clk_i(clk), .clr_ni(clr_n), .load_ni(load_n), .preset_i(pre),
      .cnt_en_p_i(cen[g]), .cnt_en_t_i(cen[g]), .count_o(cq[g]), .carry_o(cc[g]));
  end

  function automatic int term_of(input int v);
    return (v >= 2) ? 9 : 15;
  endfunction

  function automatic int next_of(input int p, input int v);
    return (p == term_of(v)) ? 0 : (p + 1) % 16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr_n = 1'b0; load_n = 1'b0; pre = 4'd7; pe = 1'b1; te = 1'b1; run = 1'b0;
    tick();
    // R1 R2: clear beats load
    for (int v = 0; v < 4; v++) begin
      check("R1/R2 reset count", int'(q[v]), 0);
      check("R7 reset carry", int'(c[v]), 0);
    end
    clr_n = 1'b1;

    for (int p = 0; p < 16; p++) begin
      for (int en = 0; en < 4; en++) begin
        pre = 4'(p); load_n = 1'b0; pe = en[0]; te = en[1];
        tick();
        for (int v = 0; v < 4; v++) begin
          check("R3 load", int'(q[v]), p);
          // R7 R8: carry only at terminal with te, pe irrelevant
          check((v >= 2 && p > 9) ? "R8 carry" : "R7 carry", int'(c[v]),
                (en[1] && p == term_of(v)) ? 1 : 0);
        end
        load_n = 1'b1;
        tick();
        for (int v = 0; v < 4; v++) begin
          if (en != 3)
            check("R5 hold", int'(q[v]), p);
          else if (v >= 2 && p > 9)
            check("R8 step", int'(q[v]), next_of(p, v));
          else if (p == term_of(v))
            check("R6 wrap", int'(q[v]), 0);
          else
            check("R4 step", int'(q[v]), next_of(p, v));
        end
      end
    end

    pre = 4'd5; load_n = 1'b0; pe = 1'b1; te = 1'b1;
    tick();
    clr_n = 1'b0;
    #1;
    check("R1 sync waits", int'(q[0]), 5);
    check("R1 sync waits", int'(q[2]), 5);
    check("R2 async now", int'(q[1]), 0);
    check("R2 async now", int'(q[3]), 0);
    tick();
    for (int v = 0; v < 4; v++) check("R1/R2 cleared", int'(q[v]), 0);
    tick();
    check("R2 held low", int'(q[3]), 0);
    clr_n = 1'b1; load_n = 1'b1; run = 1'b1;

    // R9: three decade stages, modulus 1000
    for (int k = 1; k <= 1100; k++) begin
      tick();
      check("R9 chain value", int'(cq[0]) + 10 * int'(cq[1]) + 100 * int'(cq[2]), k % 1000);
      check("R9 chain carry", int'(cc[NST-1]), (k % 1000 == 999) ? 1 : 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule